// File: doc/BRIEF.md
# Subkey Derivation Unit

This block performs the second half of a 64-bit block cipher's key expansion. Given four 32-bit intermediate words (KA, KB, KC, KD) produced earlier by the round function, it derives seventeen 32-bit subkeys: four whitening keys (KW1..KW4), eleven round keys (K1..K11) and two keys for the mixing layer (KFA1, KFA2). Every derivation uses only bitwise AND, OR, XOR, a one-bit right rotation and fixed 32-bit constants.

A start strobe captures the four input words. A single shared logic unit, fed by operand multiplexers, then produces one word per clock cycle. It walks a fixed schedule of twenty steps: three helper words first, then the seventeen subkeys in dependency order. Each result goes into an internal register file. The ready flag rises once the last subkey is stored. The round engine reads subkeys by index through a registered read port.

Top module: `keyx_subkey_unit`

## Requirements
- R1: After synchronous reset, `ready` is 0, `rd_data` is 0 and every subkey slot reads back as 0.
- R2: Three helper words are derived first: KE = (KA & KB) ^ KC, then KF = (KA | KB) ^ KD, then KG = (KF & KE) ^ KA.
- R3: Index 0 holds KW1 = (KE & KF) ^ KG. Index 1 holds KW2 = (KF & KG) ^ KD.
- R4: Indices 2..5 hold K1 = (KE & KW2) ^ KF, K2 = (KG & KE) ^ KW1, K3 = (KW1 & KW2) ^ K2 and K4 = (K1 & KW2) ^ K3.
- R5: The constant-using keys are computed with C1 = D62F59FB, C2 = D597BEF1 and C3 = E4F92E2D (hex). Index 6 holds KFA1 = (C1 & KE) ^ K4. Index 7 holds K5 = (C2 & K3) ^ KW2. Index 11 holds K8 = (C3 & K3) ^ K7.
- R6: Index 8 holds K6 = (K1 & K2) ^ K5.
- R7: Index 12 holds K9 = ror1(K5) ^ K3. In ror1, bit 31 of the result is bit 0 of K5 and bit i is bit i+1.
- R8: The remaining indices hold the following keys:
  - index 9: K7 = (K6 & KW2) ^ KFA1
  - index 10: KFA2 = (K1 & K5) ^ K6
  - index 13: K10 = (K8 & K4) ^ K5
  - index 14: K11 = (K3 & K5) ^ K6
  - index 15: KW3 = (K9 & K4) ^ K6
  - index 16: KW4 = (K2 & K8) ^ K9
- R9: `ready` is 0 in the cycle after a start edge. It becomes 1 right after the 20th rising edge following the start edge, and it holds 1 until the next start.
- R10: The read port is registered. `rd_data` shows slot `rd_idx` after the next rising edge. Indices 17..31 read as 0.
- R11: A start during a derivation abandons it. The unit restarts from the new input words, and `ready` again rises 20 edges after the new start.
- R12: If a read and the write of the same slot fall on one edge, the read returns the slot's previous content.
- R13: KA..KD are sampled only on the start edge. Later changes to them have no effect on the derived subkeys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture KA..KD and begin derivation |
| ka | input | 32 | Intermediate word KA |
| kb | input | 32 | Intermediate word KB |
| kc | input | 32 | Intermediate word KC |
| kd | input | 32 | Intermediate word KD |
| rd_idx | input | 5 | Subkey read index |
| rd_data | output | 32 | Registered subkey read data |
| ready | output | 1 | All subkeys derived and stored |

## Verification
A subkey read and the derivation's write of that same slot can fall on a single clock edge. The bench provokes this by starting a second derivation over a filled register file and pointing `rd_idx` at index 0 so that the read lands on the edge that writes KW1. The read must return the first derivation's KW1, and the read on the next edge must return the new value. Start strobes arriving during a derivation, and input words that change after the start edge, are judged against a bench model of the equations.

// File: rtl/keyx_pkg.sv
package keyx_pkg;

    localparam int WORD_W      = 32;
    localparam int NUM_SUBKEYS = 17;
    localparam int NUM_SLOTS   = 24;
    localparam int NUM_STEPS   = 20;
    localparam int SEL_W       = 5;
    localparam int STEP_W      = $clog2(NUM_STEPS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [STEP_W-1:0] step_idx_t;

    localparam step_idx_t LAST_STEP = step_idx_t'(NUM_STEPS - 1);
    localparam sel_t      SUBKEY_END = sel_t'(NUM_SUBKEYS);

    // Constants: fractional square-root digits
    localparam word_t CONST_1 = 32'hD62F59FB;
    localparam word_t CONST_2 = 32'hD597BEF1;
    localparam word_t CONST_3 = 32'hE4F92E2D;

    // Readable subkey slots (index order seen by the round engine)
    localparam sel_t IX_KW1  = 5'd0;
    localparam sel_t IX_KW2  = 5'd1;
    localparam sel_t IX_K1   = 5'd2;
    localparam sel_t IX_K2   = 5'd3;
    localparam sel_t IX_K3   = 5'd4;
    localparam sel_t IX_K4   = 5'd5;
    localparam sel_t IX_KFA1 = 5'd6;
    localparam sel_t IX_K5   = 5'd7;
    localparam sel_t IX_K6   = 5'd8;
    localparam sel_t IX_K7   = 5'd9;
    localparam sel_t IX_KFA2 = 5'd10;
    localparam sel_t IX_K8   = 5'd11;
    localparam sel_t IX_K9   = 5'd12;
    localparam sel_t IX_K10  = 5'd13;
    localparam sel_t IX_K11  = 5'd14;
    localparam sel_t IX_KW3  = 5'd15;
    localparam sel_t IX_KW4  = 5'd16;
    // Hidden working slots
    localparam sel_t SL_KE   = 5'd17;
    localparam sel_t SL_KF   = 5'd18;
    localparam sel_t SL_KG   = 5'd19;
    localparam sel_t SL_KA   = 5'd20;
    localparam sel_t SL_KB   = 5'd21;
    localparam sel_t SL_KC   = 5'd22;
    localparam sel_t SL_KD   = 5'd23;
    // Constant operand sources (not storage)
    localparam sel_t SRC_C1  = 5'd24;
    localparam sel_t SRC_C2  = 5'd25;
    localparam sel_t SRC_C3  = 5'd26;

    typedef enum logic [1:0] {
        MIX_AND_XOR = 2'd0,   // (a & b) ^ c
        MIX_OR_XOR  = 2'd1,   // (a | b) ^ c
        MIX_ROR_XOR = 2'd2    // ror1(a) ^ c
    } mix_op_e;

    typedef struct packed {
        mix_op_e op;
        sel_t    src_a;
        sel_t    src_b;
        sel_t    src_c;
        sel_t    dst;
    } step_t;

    function automatic step_t mk(input mix_op_e op, input sel_t a, input sel_t b,
                                 input sel_t c, input sel_t d);
        step_t s;
        s.op    = op;
        s.src_a = a;
        s.src_b = b;
        s.src_c = c;
        s.dst   = d;
        return s;
    endfunction

    // Fixed derivation schedule, one step per cycle, in dependency order
    function automatic step_t step_plan(input step_idx_t s);
        step_t r;
        case (s)
            5'd0:    r = mk(MIX_AND_XOR, SL_KA,   SL_KB,   SL_KC,   SL_KE);
            5'd1:    r = mk(MIX_OR_XOR,  SL_KA,   SL_KB,   SL_KD,   SL_KF);
            5'd2:    r = mk(MIX_AND_XOR, SL_KF,   SL_KE,   SL_KA,   SL_KG);
            5'd3:    r = mk(MIX_AND_XOR, SL_KE,   SL_KF,   SL_KG,   IX_KW1);
            5'd4:    r = mk(MIX_AND_XOR, SL_KF,   SL_KG,   SL_KD,   IX_KW2);
            5'd5:    r = mk(MIX_AND_XOR, SL_KE,   IX_KW2,  SL_KF,   IX_K1);
            5'd6:    r = mk(MIX_AND_XOR, SL_KG,   SL_KE,   IX_KW1,  IX_K2);
            5'd7:    r = mk(MIX_AND_XOR, IX_KW1,  IX_KW2,  IX_K2,   IX_K3);
            5'd8:    r = mk(MIX_AND_XOR, IX_K1,   IX_KW2,  IX_K3,   IX_K4);
            5'd9:    r = mk(MIX_AND_XOR, SRC_C1,  SL_KE,   IX_K4,   IX_KFA1);
            5'd10:   r = mk(MIX_AND_XOR, SRC_C2,  IX_K3,   IX_KW2,  IX_K5);
            5'd11:   r = mk(MIX_AND_XOR, IX_K1,   IX_K2,   IX_K5,   IX_K6);
            5'd12:   r = mk(MIX_AND_XOR, IX_K6,   IX_KW2,  IX_KFA1, IX_K7);
            5'd13:   r = mk(MIX_AND_XOR, IX_K1,   IX_K5,   IX_K6,   IX_KFA2);
            5'd14:   r = mk(MIX_AND_XOR, SRC_C3,  IX_K3,   IX_K7,   IX_K8);
            5'd15:   r = mk(MIX_ROR_XOR, IX_K5,   IX_K5,   IX_K3,   IX_K9);
            5'd16:   r = mk(MIX_AND_XOR, IX_K8,   IX_K4,   IX_K5,   IX_K10);
            5'd17:   r = mk(MIX_AND_XOR, IX_K3,   IX_K5,   IX_K6,   IX_K11);
            5'd18:   r = mk(MIX_AND_XOR, IX_K9,   IX_K4,   IX_K6,   IX_KW3);
            default: r = mk(MIX_AND_XOR, IX_K2,   IX_K8,   IX_K9,   IX_KW4);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/keyx_mix.sv
module keyx_mix
    import keyx_pkg::*;
(
    input  mix_op_e op,
    input  word_t   opa,
    input  word_t   opb,
    input  word_t   opc,
    output word_t   res
);
    always_comb begin
        case (op)
            MIX_AND_XOR: res = (opa & opb) ^ opc;
            MIX_OR_XOR:  res = (opa | opb) ^ opc;
            MIX_ROR_XOR: res = {opa[0], opa[WORD_W-1:1]} ^ opc;
            default:     res = '0;
        endcase
    end
endmodule

// File: rtl/keyx_seq.sv
module keyx_seq
    import keyx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output logic      busy,
    output logic      ready,
    output step_idx_t step
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ready <= 1'b0;
            step  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ready <= 1'b0;
            step  <= '0;
        end else if (busy) begin
            if (step == LAST_STEP) begin
                busy  <= 1'b0;
                ready <= 1'b1;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    p_start_restarts_r11: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !ready && step == '0));

    p_last_sets_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && step == LAST_STEP) |=> (ready && !busy));

    p_step_advance_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && step != LAST_STEP) |=> (busy && step == $past(step) + 1'b1));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ready |-> !busy);
endmodule

// File: rtl/keyx_store.sv
module keyx_store
    import keyx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t ka,
    input  word_t kb,
    input  word_t kc,
    input  word_t kd,
    input  logic  wr_en,
    input  sel_t  wr_sel,
    input  word_t wr_data,
    input  sel_t  sel_a,
    input  sel_t  sel_b,
    input  sel_t  sel_c,
    output word_t opa,
    output word_t opb,
    output word_t opc,
    input  sel_t  rd_idx,
    output word_t rd_data
);
    word_t mem [NUM_SLOTS];

    function automatic word_t fetch(input sel_t s, input word_t m [NUM_SLOTS]);
        word_t v;
        case (s)
            SRC_C1:  v = CONST_1;
            SRC_C2:  v = CONST_2;
            SRC_C3:  v = CONST_3;
            default: v = (s < sel_t'(NUM_SLOTS)) ? m[s] : '0;
        endcase
        return v;
    endfunction

    always_comb begin
        opa = fetch(sel_a, mem);
        opb = fetch(sel_b, mem);
        opc = fetch(sel_c, mem);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) mem[i] <= '0;
            rd_data <= '0;
        end else begin
            if (load) begin
                mem[SL_KA] <= ka;
                mem[SL_KB] <= kb;
                mem[SL_KC] <= kc;
                mem[SL_KD] <= kd;
            end else if (wr_en) begin
                mem[wr_sel] <= wr_data;
            end
            rd_data <= (rd_idx < SUBKEY_END) ? mem[rd_idx] : '0;
        end
    end

    p_rd_high_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_idx >= SUBKEY_END) |=> (rd_data == '0));

    p_keys_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !load |=> (mem[SL_KA] == $past(mem[SL_KA]) && mem[SL_KD] == $past(mem[SL_KD])));

    p_write_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_sel < SL_KA));
endmodule

// File: rtl/keyx_subkey_unit.sv
module keyx_subkey_unit
    import keyx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] ka,
    input  logic [WORD_W-1:0] kb,
    input  logic [WORD_W-1:0] kc,
    input  logic [WORD_W-1:0] kd,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              ready
);
    logic      busy;
    step_idx_t step;
    step_t     cur;
    word_t     opa, opb, opc, mix_res;
    logic      wr_en;

    keyx_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .ready (ready),
        .step  (step)
    );

    assign cur   = step_plan(step);
    assign wr_en = busy & ~start;

    keyx_store u_store (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .ka      (ka),
        .kb      (kb),
        .kc      (kc),
        .kd      (kd),
        .wr_en   (wr_en),
        .wr_sel  (cur.dst),
        .wr_data (mix_res),
        .sel_a   (cur.src_a),
        .sel_b   (cur.src_b),
        .sel_c   (cur.src_c),
        .opa     (opa),
        .opb     (opb),
        .opc     (opc),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    keyx_mix u_mix (
        .op  (cur.op),
        .opa (opa),
        .opb (opb),
        .opc (opc),
        .res (mix_res)
    );

    p_start_drops_ready_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready);

    p_ready_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready);
endmodule

// File: tb/keyx_subkey_unit_test.sv
`timescale 1ns/1ps
module keyx_subkey_unit_test;

    typedef logic [31:0] sk_arr_t [17];

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] ka = '0, kb = '0, kc = '0, kd = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        ready;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    keyx_subkey_unit uut (
        .clk(clk), .rst(rst), .start(start),
        .ka(ka), .kb(kb), .kc(kc), .kd(kd),
        .rd_idx(rd_idx), .rd_data(rd_data), .ready(ready)
    );

    localparam logic [127:0] VECS [4] = '{
        128'h00000000_00000000_00000000_00000000,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'h01234567_89ABCDEF_FEDCBA98_76543210,
        128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0
    };

    function automatic sk_arr_t model(input logic [127:0] v);
        logic [31:0] a, b, c, d, e, f, g;
        sk_arr_t r;
        a = v[127:96]; b = v[95:64]; c = v[63:32]; d = v[31:0];
        e = (a & b) ^ c;                               // R2
        f = (a | b) ^ d;
        g = (f & e) ^ a;
        r[0]  = (e & f) ^ g;                           // KW1
        r[1]  = (f & g) ^ d;                           // KW2
        r[2]  = (e & r[1]) ^ f;                        // K1
        r[3]  = (g & e) ^ r[0];                        // K2
        r[4]  = (r[0] & r[1]) ^ r[3];                  // K3
        r[5]  = (r[2] & r[1]) ^ r[4];                  // K4
        r[6]  = (32'hD62F59FB & e) ^ r[5];             // KFA1
        r[7]  = (32'hD597BEF1 & r[4]) ^ r[1];          // K5
        r[8]  = (r[2] & r[3]) ^ r[7];                  // K6
        r[9]  = (r[8] & r[1]) ^ r[6];                  // K7
        r[10] = (r[2] & r[7]) ^ r[8];                  // KFA2
        r[11] = (32'hE4F92E2D & r[4]) ^ r[9];          // K8
        r[12] = {r[7][0], r[7][31:1]} ^ r[4];          // K9
        r[13] = (r[11] & r[5]) ^ r[7];                 // K10
        r[14] = (r[4] & r[7]) ^ r[8];                  // K11
        r[15] = (r[12] & r[5]) ^ r[8];                 // KW3
        r[16] = (r[3] & r[11]) ^ r[12];                // KW4
        return r;
    endfunction

    function automatic string req_of(input int i);
        case (i)
            0, 1:        return "R2/R3";
            2, 3, 4, 5:  return "R4";
            6, 7, 11:    return "R5";
            8:           return "R6";
            12:          return "R7";
            default:     return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] i, output logic [31:0] v);
        rd_idx = i;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic begin_run(input logic [127:0] v);
        {ka, kb, kc, kd} = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // waits edges 1..20 after the start edge, checking ready each cycle
    task automatic wait_ready(input string req);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            chk(req, $sformatf("ready after edge %0d", k), {31'b0, ready}, {31'b0, (k == 20)});
        end
    endtask

    task automatic check_all(input logic [127:0] v, input string tag);
        sk_arr_t exp;
        logic [31:0] got;
        exp = model(v);
        for (int i = 0; i < 17; i++) begin
            rd(5'(i), got);
            chk(req_of(i), $sformatf("%s idx %0d", tag, i), got, exp[i]);
        end
        rd(5'd17, got);
        chk("R10", "idx 17 reads zero", got, 32'h0);
        rd(5'd31, got);
        chk("R10", "idx 31 reads zero", got, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        sk_arr_t old_k, new_k;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", {31'b0, ready}, 32'h0);
        chk("R1", "rd_data in reset", rd_data, 32'h0);
        rst = 1'b0;
        rd(5'd0, got);
        chk("R1", "slot 0 after reset", got, 32'h0);
        rd(5'd16, got);
        chk("R1", "slot 16 after reset", got, 32'h0);
        chk("R1", "ready stays low", {31'b0, ready}, 32'h0);

        // Vector table walk (R2..R10)
        for (int v = 0; v < 4; v++) begin
            begin_run(VECS[v]);
            wait_ready("R9");
            check_all(VECS[v], $sformatf("vec%0d", v));
            chk("R9", "ready held after reads", {31'b0, ready}, 32'h1);
        end

        // R12: same-edge read and write of KW1 returns old content
        old_k = model(VECS[3]);
        new_k = model(VECS[2]);
        begin_run(VECS[2]);                    // now after start edge
        repeat (3) @(negedge clk);             // after edges 1..3
        rd_idx = 5'd0;
        @(negedge clk);                        // edge 4 writes KW1
        chk("R12", "read on write edge", rd_data, old_k[0]);
        @(negedge clk);
        chk("R12", "read after write edge", rd_data, new_k[0]);
        repeat (14) @(negedge clk);            // edges 6..19
        chk("R9", "ready low at edge 19", {31'b0, ready}, 32'h0);
        @(negedge clk);
        chk("R9", "ready high at edge 20", {31'b0, ready}, 32'h1);

        // R13: input changes after start are ignored
        begin_run(VECS[1]);
        {ka, kb, kc, kd} = VECS[2];
        wait_ready("R13");
        check_all(VECS[1], "R13 held inputs");

        // R11: restart mid-derivation
        begin_run(VECS[3]);
        repeat (7) @(negedge clk);
        chk("R11", "ready low mid-run", {31'b0, ready}, 32'h0);
        begin_run(VECS[2]);
        wait_ready("R11");
        check_all(VECS[2], "R11 restart");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule